// File: doc/BRIEF.md
# NAND Flash Bus Cycle Engine

This block sits on the host side of an 8-bit parallel NAND flash device and turns simple requests into correctly ordered bus cycles. A requester hands over one operation at a time on a valid/ready port: send a command byte, send a full address, program a run of data bytes, or fetch a run of data bytes. The engine then drives the chip select, the two latch-enable lines, the write and read strobes and the data bus with its output enable. When the transfer is over it raises a one-cycle completion pulse.

Strobe low and high times are parameters counted in system clocks. Any setting below two clocks is raised to two. Data to be programmed arrives on a byte stream with valid/ready. Fetched bytes leave in order on a second byte stream. A fetched byte is sampled either at the end of the read strobe's low phase or at the end of its high phase. The choice is made at elaboration from the read strobe period, which is the clock period times the sum of the low and high counts. A device ready flag keeps new requests waiting while the flash reports busy.

Top module: `nandbus_seq`

## Requirements
- R1: A command request (op code 0) makes exactly one write-strobe pulse. While the strobe rises, the bus shows select low, command latch high, address latch low, read strobe high, output enable high and the request's command byte.
- R2: An address request (op code 1) makes exactly five write-strobe pulses with the address latch high and the command latch low. Bytes go out least significant first: address bits 7:0, then 15:8, and so on up to 39:32.
- R3: A data-write request (op code 2) of length N makes N write-strobe pulses, one per byte taken from the write stream, in stream order. Both latch enables are low and the output enable is high.
- R4: A data-read request (op code 3) of length N makes N read-strobe pulses. The write strobe stays high, both latches are low, the output enable is low while the read strobe is low, and the two strobes are never low together.
- R5: Each strobe's low phase lasts exactly max(low count, 2) clocks. Its high phase between pulses lasts at least max(high count, 2) clocks.
- R6: Between requests, select is high, both strobes are high, both latches are low and the output enable is off.
- R7: When the read strobe period exceeds 30 ns, each byte is sampled from the flash on the clock edge where the read strobe rises.
- R8: When the read strobe period is 30 ns or less, each byte is sampled on the last clock edge of the strobe's high phase.
- R9: Each request ends with a done pulse exactly one cycle long. The pulse comes after the final strobe rise, while both strobes are high. For a burst of n byte cycles without stalls, done is seen n*(1+low+high) clocks after the accepting edge.
- R10: While the device ready flag is low, req_ready stays low and no strobe moves.
- R11: A data request of length 0 produces no strobe pulse, and done follows one clock after acceptance.
- R12: While a fetched byte waits on the read stream it holds steady, and no further read pulse starts. No byte is lost or reordered.
- R13: During a data write, no write-strobe pulse starts while the write stream has no valid byte.
- R14: After reset, all bus lines are idle, done and rd_valid are low, and req_ready follows the device ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken this cycle when also valid |
| req_op | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_byte | input | 8 | Command byte |
| req_addr | input | 40 | Five address bytes, lowest sent first |
| req_len | input | LEN_W | Byte count for data requests |
| wr_valid | input | 1 | Write stream byte valid |
| wr_ready | output | 1 | Write stream byte taken |
| wr_byte | input | 8 | Byte to program |
| rd_valid | output | 1 | Fetched byte valid |
| rd_ready | input | 1 | Fetched byte accepted |
| rd_byte | output | 8 | Fetched byte |
| done | output | 1 | One-cycle end-of-request pulse |
| nand_rdy | input | 1 | Device ready flag, high when ready |
| nand_ce_n | output | 1 | Chip select, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_oe | output | 1 | Host drives the data bus when high |
| nand_dq_out | output | 8 | Bus byte driven by the host |
| nand_dq_in | input | 8 | Bus byte driven by the flash |

## Verification
The checks assume that the requester keeps the op code and operands stable until acceptance, and that data requests carry a length within LEN_W. They also assume the flash drives a read byte only inside the window that matches the configured capture edge. The bench keeps request fields steady while valid is high. Its flash model puts each byte on the bus only during the strobe phase that the active capture mode needs, and shows a junk value otherwise, so sampling in the wrong phase becomes visible. Stalls on both streams are applied only during data requests of the matching direction.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    typedef enum logic [1:0] {
        OP_CMD   = 2'd0,
        OP_ADDR  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } nbs_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LOW,
        ST_HIGH,
        ST_FIN
    } nbs_state_e;

    typedef struct packed {
        logic       ce_n;
        logic       cle;
        logic       ale;
        logic       we_n;
        logic       re_n;
        logic       oe;
        logic [7:0] dq;
    } nbs_pins_t;

    localparam int NBS_ADDR_CYCLES    = 5;
    localparam int NBS_SLOW_PERIOD_PS = 30000;

    // strobe phases never shorter than two clocks
    function automatic int nbs_min2(input int v);
        return (v < 2) ? 2 : v;
    endfunction

    function automatic nbs_pins_t nbs_idle_pins();
        nbs_pins_t p;
        p.ce_n = 1'b1;
        p.cle  = 1'b0;
        p.ale  = 1'b0;
        p.we_n = 1'b1;
        p.re_n = 1'b1;
        p.oe   = 1'b0;
        p.dq   = 8'h00;
        return p;
    endfunction

endpackage

// File: rtl/nbs_timer.sv
module nbs_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] span,
    output logic          expire
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= span - CW'(1);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign expire = (cnt == '0);

    // R5
    span_min_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> !expire);
endmodule

// File: rtl/nbs_rdbuf.sv
module nbs_rdbuf (
    input  logic       clk,
    input  logic       rst,
    input  logic       cap,
    input  logic [7:0] cap_byte,
    input  logic       rd_ready,
    output logic       rd_valid,
    output logic [7:0] rd_byte
);
    logic       valid_q;
    logic [7:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            byte_q  <= 8'h00;
        end else if (cap) begin
            valid_q <= 1'b1;
            byte_q  <= cap_byte;
        end else if (rd_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign rd_valid = valid_q;
    assign rd_byte  = byte_q;

    // R12
    no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        cap |-> !valid_q);
    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_byte)));
endmodule

// File: rtl/nandbus_seq.sv
module nandbus_seq
    import nbs_pkg::*;
#(
    parameter int CLK_PS = 4000,
    parameter int WE_LO  = 3,
    parameter int WE_HI  = 2,
    parameter int RE_LO  = 4,
    parameter int RE_HI  = 4,
    parameter int LEN_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [7:0]       req_byte,
    input  logic [39:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_byte,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_byte,
    output logic             done,
    input  logic             nand_rdy,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic             nand_dq_oe,
    output logic [7:0]       nand_dq_out,
    input  logic [7:0]       nand_dq_in
);
    localparam int WL_E  = nbs_min2(WE_LO);
    localparam int WH_E  = nbs_min2(WE_HI);
    localparam int RL_E  = nbs_min2(RE_LO);
    localparam int RH_E  = nbs_min2(RE_HI);
    localparam int TM_W  = (WL_E > WH_E) ? WL_E : WH_E;
    localparam int TM_R  = (RL_E > RH_E) ? RL_E : RH_E;
    localparam int TMAX  = (TM_W > TM_R) ? TM_W : TM_R;
    localparam int TW    = $clog2(TMAX + 1);
    localparam int RD_PERIOD_PS = (RL_E + RH_E) * CLK_PS;
    localparam bit SLOW_CAP     = (RD_PERIOD_PS > NBS_SLOW_PERIOD_PS);

    nbs_state_e        st, st_nxt;
    nbs_op_e           op_q;
    nbs_op_e           req_op_e;
    logic [LEN_W-1:0]  left_q;
    logic [39:0]       ash_q;
    logic [7:0]        cmd_q;
    nbs_pins_t         pin_q;
    logic              done_q;
    logic              is_rd;
    logic              last_byte;
    logic              accept;
    logic              go;
    logic              tmr_load;
    logic [TW-1:0]     tmr_span;
    logic              tmr_exp;
    logic              cap;
    logic              rd_valid_w;

    assign req_op_e  = nbs_op_e'(req_op);
    assign is_rd     = (op_q == OP_READ);
    assign last_byte = (left_q == LEN_W'(1));
    assign req_ready = (st == ST_IDLE) && nand_rdy;
    assign accept    = req_ready && req_valid;
    assign wr_ready  = (st == ST_LOAD) && (op_q == OP_WRITE);

    always_comb begin
        st_nxt   = st;
        tmr_load = 1'b0;
        tmr_span = is_rd ? TW'(RL_E) : TW'(WL_E);
        go       = 1'b0;
        case (st)
            ST_IDLE: begin
                if (accept)
                    st_nxt = (req_op[1] && req_len == '0) ? ST_FIN : ST_LOAD;
            end
            ST_LOAD: begin
                case (op_q)
                    OP_WRITE: go = wr_valid;
                    OP_READ:  go = !rd_valid_w;
                    default:  go = 1'b1;
                endcase
                if (go) begin
                    st_nxt   = ST_LOW;
                    tmr_load = 1'b1;
                end
            end
            ST_LOW: begin
                if (tmr_exp) begin
                    st_nxt   = ST_HIGH;
                    tmr_load = 1'b1;
                    tmr_span = is_rd ? TW'(RH_E) : TW'(WH_E);
                end
            end
            ST_HIGH: begin
                if (tmr_exp)
                    st_nxt = last_byte ? ST_IDLE : ST_LOAD;
            end
            ST_FIN:  st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            op_q   <= OP_CMD;
            left_q <= '0;
            ash_q  <= '0;
            cmd_q  <= 8'h00;
            pin_q  <= nbs_idle_pins();
            done_q <= 1'b0;
        end else begin
            st     <= st_nxt;
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        op_q       <= req_op_e;
                        cmd_q      <= req_byte;
                        ash_q      <= req_addr;
                        left_q     <= (req_op_e == OP_CMD)  ? LEN_W'(1) :
                                      (req_op_e == OP_ADDR) ? LEN_W'(NBS_ADDR_CYCLES) :
                                      req_len;
                        pin_q.ce_n <= 1'b0;
                        pin_q.cle  <= (req_op_e == OP_CMD);
                        pin_q.ale  <= (req_op_e == OP_ADDR);
                        pin_q.oe   <= (req_op_e != OP_READ);
                    end
                end
                ST_LOAD: begin
                    if (go) begin
                        pin_q.we_n <= is_rd;
                        pin_q.re_n <= !is_rd;
                        case (op_q)
                            OP_WRITE: pin_q.dq <= wr_byte;
                            OP_ADDR:  pin_q.dq <= ash_q[7:0];
                            OP_CMD:   pin_q.dq <= cmd_q;
                            default:  pin_q.dq <= pin_q.dq;
                        endcase
                    end
                end
                ST_LOW: begin
                    if (tmr_exp) begin
                        pin_q.we_n <= 1'b1;
                        pin_q.re_n <= 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (tmr_exp) begin
                        left_q <= left_q - LEN_W'(1);
                        ash_q  <= ash_q >> 8;
                        if (last_byte) begin
                            pin_q  <= nbs_idle_pins();
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_FIN: begin
                    pin_q  <= nbs_idle_pins();
                    done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    nbs_timer #(.CW(TW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (tmr_load),
        .span   (tmr_span),
        .expire (tmr_exp)
    );

    generate
        if (SLOW_CAP) begin : g_cap_rise
            assign cap = (st == ST_LOW) && tmr_exp && is_rd;
        end else begin : g_cap_late
            assign cap = (st == ST_HIGH) && tmr_exp && is_rd;
        end
    endgenerate

    nbs_rdbuf u_rdbuf (
        .clk      (clk),
        .rst      (rst),
        .cap      (cap),
        .cap_byte (nand_dq_in),
        .rd_ready (rd_ready),
        .rd_valid (rd_valid_w),
        .rd_byte  (rd_byte)
    );

    assign rd_valid    = rd_valid_w;
    assign done        = done_q;
    assign nand_ce_n   = pin_q.ce_n;
    assign nand_cle    = pin_q.cle;
    assign nand_ale    = pin_q.ale;
    assign nand_we_n   = pin_q.we_n;
    assign nand_re_n   = pin_q.re_n;
    assign nand_dq_oe  = pin_q.oe;
    assign nand_dq_out = pin_q.dq;

    // R1
    latch_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));
    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        nand_we_n || nand_re_n);
    // R4
    rd_release_chk: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |-> !nand_dq_oe);
    // R5
    we_lo_min_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(nand_we_n) |=> !nand_we_n);
    // R5
    re_lo_min_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(nand_re_n) |=> !nand_re_n);
    // R5
    we_hi_min_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_we_n) |=> nand_we_n);
    // R6
    idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
        nand_ce_n |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe));
    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (nand_we_n && nand_re_n));
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !nand_rdy |-> !req_ready);
    // R13
    wr_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ready && !wr_valid) |=> nand_we_n);
endmodule

// File: tb/sim_nandbus_seq.sv
`timescale 1ns/1ps

module sim_probe (
    input logic       clk,
    input logic       clr,
    input logic       ce_n,
    input logic       cle,
    input logic       ale,
    input logic       we_n,
    input logic       re_n,
    input logic       oe,
    input logic [7:0] dq,
    input logic       done
);
    int n_we, n_re, n_done, idle_bad, oe_bad;
    int we_lo_min, we_lo_max, we_hi_min, re_lo_min, re_lo_max;
    int we_run, we_hrun, re_run;
    logic we_p, re_p;
    logic [7:0] wb [0:15];
    logic [4:0] wf [0:15];

    always @(negedge clk) begin
        if (clr) begin
            n_we = 0; n_re = 0; n_done = 0; idle_bad = 0; oe_bad = 0;
            we_lo_min = 999; we_lo_max = 0; we_hi_min = 999;
            re_lo_min = 999; re_lo_max = 0;
            we_run = 0; we_hrun = 0; re_run = 0; we_p = 1'b1; re_p = 1'b1;
        end else begin
            if (!we_n) begin
                if (we_p && n_we > 0 && we_hrun < we_hi_min) we_hi_min = we_hrun;
                we_hrun = 0;
                we_run++;
            end else begin
                if (!we_p) begin
                    if (n_we < 16) begin
                        wb[n_we] = dq;
                        wf[n_we] = {ce_n, cle, ale, re_n, oe};
                    end
                    n_we++;
                    if (we_run < we_lo_min) we_lo_min = we_run;
                    if (we_run > we_lo_max) we_lo_max = we_run;
                    we_run = 0;
                end
                we_hrun++;
            end
            if (!re_n) begin
                re_run++;
            end else if (!re_p) begin
                n_re++;
                if (re_run < re_lo_min) re_lo_min = re_run;
                if (re_run > re_lo_max) re_lo_max = re_run;
                re_run = 0;
            end
            we_p = we_n;
            re_p = re_n;
            if (!re_n && oe) oe_bad++;
            if (ce_n && (!we_n || !re_n || cle || ale || oe)) idle_bad++;
            if (done) n_done++;
        end
    end
endmodule

module sim_nandbus_seq;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    logic rst, pclr;
    logic req_valid, req_valid1, req_ready, req_ready1;
    logic [1:0] req_op;
    logic [7:0] req_byte;
    logic [39:0] req_addr;
    logic [7:0] req_len;
    logic wr_valid, wr_ready, wr_hold, wr_ready1;
    logic [7:0] wr_byte;
    logic rd_valid, rd_ready, rd_valid1;
    logic [7:0] rd_byte, rd_byte1;
    logic done, done1, nand_rdy;
    logic ce_n0, cle0, ale0, we0, re0, oe0, ce_n1, cle1, ale1, we1, re1, oe1;
    logic [7:0] dqo0, dqo1, dq_in0, dq_in1;

    logic [7:0] wr_mem [0:7];
    int wr_n, wr_i, rd_n, rd_n1, rc0, rc1;
    logic [7:0] rd_log [0:15];
    logic [7:0] rd_log1 [0:15];

    assign wr_valid = !wr_hold && (wr_i < wr_n);
    assign wr_byte  = wr_mem[wr_i[2:0]];

    always @(posedge clk) if (wr_valid && wr_ready) wr_i <= wr_i + 1;
    always @(posedge clk) if (rd_valid && rd_ready) begin
        rd_log[rd_n[3:0]] <= rd_byte; rd_n <= rd_n + 1;
    end
    always @(posedge clk) if (rd_valid1) begin
        rd_log1[rd_n1[3:0]] <= rd_byte1; rd_n1 <= rd_n1 + 1;
    end

    // flash model, slow instance: byte present only while read strobe is low
    always @(negedge re0) begin #1 dq_in0 = 8'h30 + rc0[7:0]; end
    always @(posedge re0) begin rc0 = rc0 + 1; #1 dq_in0 = 8'hEE; end
    // flash model, fast instance: byte present only while read strobe is high
    always @(posedge re1) begin #1 dq_in1 = 8'h70 + rc1[7:0]; rc1 = rc1 + 1; end
    always @(negedge re1) begin #1 dq_in1 = 8'hEE; end

    nandbus_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_byte(req_byte), .req_addr(req_addr), .req_len(req_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_byte(wr_byte),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_byte(rd_byte), .done(done),
        .nand_rdy(nand_rdy), .nand_ce_n(ce_n0), .nand_cle(cle0), .nand_ale(ale0),
        .nand_we_n(we0), .nand_re_n(re0), .nand_dq_oe(oe0), .nand_dq_out(dqo0),
        .nand_dq_in(dq_in0)
    );

    nandbus_seq #(.CLK_PS(4000), .WE_LO(1), .WE_HI(2), .RE_LO(2), .RE_HI(2)) u1 (
        .clk(clk), .rst(rst), .req_valid(req_valid1), .req_ready(req_ready1),
        .req_op(req_op), .req_byte(req_byte), .req_addr(req_addr), .req_len(req_len),
        .wr_valid(1'b0), .wr_ready(wr_ready1), .wr_byte(8'h00),
        .rd_valid(rd_valid1), .rd_ready(1'b1), .rd_byte(rd_byte1), .done(done1),
        .nand_rdy(1'b1), .nand_ce_n(ce_n1), .nand_cle(cle1), .nand_ale(ale1),
        .nand_we_n(we1), .nand_re_n(re1), .nand_dq_oe(oe1), .nand_dq_out(dqo1),
        .nand_dq_in(dq_in1)
    );

    sim_probe p0 (.clk(clk), .clr(pclr), .ce_n(ce_n0), .cle(cle0), .ale(ale0),
        .we_n(we0), .re_n(re0), .oe(oe0), .dq(dqo0), .done(done));
    sim_probe p1 (.clk(clk), .clr(pclr), .ce_n(ce_n1), .cle(cle1), .ale(ale1),
        .we_n(we1), .re_n(re1), .oe(oe1), .dq(dqo1), .done(done1));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clr_probes();
        @(posedge clk) pclr <= 1'b1;
        @(posedge clk) pclr <= 1'b0;
        @(negedge clk);
    endtask

    task automatic issue(input int sel, input logic [1:0] op, input logic [7:0] b,
                         input logic [39:0] a, input logic [7:0] len, output int lat);
        @(negedge clk);
        req_op = op; req_byte = b; req_addr = a; req_len = len;
        if (sel == 0) req_valid = 1'b1; else req_valid1 = 1'b1;
        while (!((sel == 0) ? req_ready : req_ready1)) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_valid1 = 1'b0;
        lat = 0;
        while (!((sel == 0) ? done : done1)) begin @(negedge clk); lat++; end
        @(negedge clk);
        chk("R9 done lasts one cycle", (sel == 0) ? done : done1, 1'b0);
    endtask

    task automatic t_reset();
        chk("R14 ce_n idle", ce_n0, 1'b1);
        chk("R14 strobes idle", {we0, re0}, 2'b11);
        chk("R14 latches and oe off", {cle0, ale0, oe0}, 3'b000);
        chk("R14 done and rd_valid low", {done, rd_valid}, 2'b00);
        chk("R14 req_ready follows flag", req_ready, 1'b1);
    endtask

    task automatic t_cmd();
        int lat;
        clr_probes();
        issue(0, 2'd0, 8'h80, 40'h0, 8'd0, lat);
        chk("R1 one write pulse", p0.n_we, 1);
        chk("R1 command byte", p0.wb[0], 8'h80);
        chk("R1 pin state at strobe rise", p0.wf[0], 5'b01011);
        chk("R1 no read pulse", p0.n_re, 0);
        chk("R5 write low width", {p0.we_lo_min[7:0], p0.we_lo_max[7:0]}, {8'd3, 8'd3});
        chk("R9 command latency", lat, 6);
        chk("R9 one done pulse", p0.n_done, 1);
        chk("R6 idle between requests", p0.idle_bad, 0);
    endtask

    task automatic t_addr();
        int lat;
        clr_probes();
        issue(0, 2'd1, 8'h00, 40'h11_22_33_44_55, 8'd0, lat);
        chk("R2 five write pulses", p0.n_we, 5);
        for (int i = 0; i < 5; i++) begin
            chk("R2 address byte order", p0.wb[i], 8'h55 - 8'(i * 8'h11));
            chk("R2 address latch state", p0.wf[i], 5'b00111);
        end
        chk("R9 address latency", lat, 30);
    endtask

    task automatic t_write();
        int lat;
        clr_probes();
        for (int i = 0; i < 4; i++) wr_mem[i] = 8'hD0 + 8'(i);
        wr_i = 0; wr_n = 4; wr_hold = 1'b1;
        fork
            issue(0, 2'd2, 8'h00, 40'h0, 8'd4, lat);
            begin
                repeat (10) @(negedge clk);
                chk("R13 no pulse while stream empty", p0.n_we, 0);
                wr_hold = 1'b0;
            end
        join
        chk("R3 four write pulses", p0.n_we, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R3 data byte order", p0.wb[i], 8'hD0 + 8'(i));
            chk("R3 data latch state", p0.wf[i], 5'b00011);
        end
        chk("R5 write high at least two", p0.we_hi_min >= 2, 1'b1);
        chk("R5 write low width", p0.we_lo_max, 3);
    endtask

    task automatic t_read();
        int lat;
        clr_probes();
        rc0 = 0; rd_n = 0; rd_ready = 1'b1;
        issue(0, 2'd3, 8'h00, 40'h0, 8'd3, lat);
        chk("R4 three read pulses", p0.n_re, 3);
        chk("R4 no write pulse", p0.n_we, 0);
        chk("R4 bus released during read", p0.oe_bad, 0);
        chk("R5 read low width", {p0.re_lo_min[7:0], p0.re_lo_max[7:0]}, {8'd4, 8'd4});
        chk("R9 read latency", lat, 27);
        chk("R7 bytes delivered", rd_n, 3);
        for (int i = 0; i < 3; i++)
            chk("R7 byte sampled at strobe rise", rd_log[i], 8'h30 + 8'(i));
    endtask

    task automatic t_backpressure();
        int lat;
        clr_probes();
        rc0 = 0; rd_n = 0; rd_ready = 1'b0;
        fork
            issue(0, 2'd3, 8'h00, 40'h0, 8'd3, lat);
            begin
                repeat (40) @(negedge clk);
                chk("R12 next pulse waits", p0.n_re, 1);
                chk("R12 byte held", {rd_valid, rd_byte}, {1'b1, 8'h30});
                rd_ready = 1'b1;
            end
        join
        chk("R12 all bytes delivered", rd_n, 3);
        for (int i = 0; i < 3; i++)
            chk("R12 order kept", rd_log[i], 8'h30 + 8'(i));
    endtask

    task automatic t_busy();
        int lat;
        clr_probes();
        nand_rdy = 1'b0;
        req_op = 2'd0; req_byte = 8'h70; req_valid = 1'b1;
        repeat (8) @(negedge clk);
        chk("R10 not ready while busy", req_ready, 1'b0);
        chk("R10 no strobe while busy", p0.n_we + p0.n_re, 0);
        chk("R10 select idle while busy", ce_n0, 1'b1);
        req_valid = 1'b0;
        nand_rdy = 1'b1;
        issue(0, 2'd0, 8'h70, 40'h0, 8'd0, lat);
        chk("R10 accepted after ready", p0.wb[0], 8'h70);
    endtask

    task automatic t_zero();
        int lat;
        clr_probes();
        issue(0, 2'd2, 8'h00, 40'h0, 8'd0, lat);
        chk("R11 zero length no pulse", p0.n_we + p0.n_re, 0);
        chk("R11 zero length latency", lat, 1);
    endtask

    task automatic t_fast();
        int lat;
        clr_probes();
        issue(1, 2'd0, 8'hFF, 40'h0, 8'd0, lat);
        chk("R5 clamped write low width", p1.we_lo_max, 2);
        chk("R9 clamped command latency", lat, 5);
        clr_probes();
        rc1 = 0; rd_n1 = 0;
        issue(1, 2'd3, 8'h00, 40'h0, 8'd3, lat);
        chk("R8 bytes delivered", rd_n1, 3);
        for (int i = 0; i < 3; i++)
            chk("R8 byte sampled at end of high", rd_log1[i], 8'h70 + 8'(i));
        chk("R5 fast read low width", p1.re_lo_max, 2);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; pclr = 1'b0; req_valid = 1'b0; req_valid1 = 1'b0;
        req_op = 2'd0; req_byte = 8'h00; req_addr = '0; req_len = 8'd0;
        wr_hold = 1'b0; wr_n = 0; wr_i = 0; rd_n = 0; rd_n1 = 0;
        rd_ready = 1'b1; nand_rdy = 1'b1; rc0 = 0; rc1 = 0;
        dq_in0 = 8'hEE; dq_in1 = 8'hEE;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cmd();
        t_addr();
        t_write();
        t_read();
        t_backpressure();
        t_busy();
        t_zero();
        t_fast();
        finish_run();
    end
endmodule